// File: doc/BRIEF.md
# Crossing-Number Minutia Detector

This block takes a thinned, one-bit ridge image as a raster-ordered pixel stream, where 1 marks a ridge pixel and 0 marks background. Two line memories hold the previous two rows, so a 3x3 neighbourhood is available around each interior pixel. For each interior ridge pixel the block walks its eight neighbours around a closed ring and counts how often the value changes between one neighbour and the next. Half of that count is the crossing number. A crossing number of one marks a ridge ending. A crossing number of three marks a bifurcation.

Each detected minutia leaves the block as a record with its column, its row and a one-bit type. Records travel on a valid/ready channel. While a record waits for the consumer, the pixel stream is held off, so no record is ever dropped. After the last pixel of a frame has been evaluated and the last record has been taken, a one-cycle done strobe reports how many records the frame produced. The next frame then starts from column 0, row 0.

Top module: `minutia_cn_detector`

## Requirements
- R1: A ridge pixel whose crossing number is 1 yields a record with type code 0 (ending).
- R2: A ridge pixel whose crossing number is 3 yields a record with type code 1 (bifurcation).
- R3: A ridge pixel whose crossing number is 0, 2 or 4 (isolated, continuing or crossing point) yields no record.
- R4: A background (0) pixel never yields a record, whatever its neighbours are.
- R5: Pixels in column 0, column IMG_W-1, row 0 or row IMG_H-1 are never reported. Interior pixels next to the border are reported normally.
- R6: A record carries the column (`rec_x`) and row (`rec_y`) of the classified pixel, counted from 0 at the top-left corner. Records leave in raster order (row by row, left to right within a row).
- R7: While `rec_valid` is high and `rec_ready` is low, the record holds stable and `pix_ready` stays low. With no record pending and no evaluation in progress, `pix_ready` is high.
- R8: Once the final pixel of a frame has been evaluated and no record is pending, `frame_done` pulses for exactly one cycle and `frame_count` equals the number of records in that frame. The count restarts from zero for the next frame.
- R9: Classification follows ring transitions and not the number of set neighbours. Neighbours are taken clockwise from east (E, SE, S, SW, W, NW, N, NE, then back to E). For example, a ridge pixel whose set neighbours are only E, SE and S is an ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready; the pixel is taken when both are high |
| pix_data | input | 1 | Pixel value: 1 ridge, 0 background |
| rec_valid | output | 1 | Minutia record valid |
| rec_ready | input | 1 | Consumer ready for the record |
| rec_x | output | $clog2(IMG_W) | Column of the minutia |
| rec_y | output | $clog2(IMG_H) | Row of the minutia |
| rec_type | output | 1 | 0 ending, 1 bifurcation |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| frame_count | output | $clog2((IMG_W-2)*(IMG_H-2)+1) | Records produced in the frame; meaningful while frame_done is high |

## Verification
Several properties hold on every cycle and are checked by assertions. A waiting record keeps its fields. The input stream is stalled whenever a record is pending. No record ever names a border pixel. The done strobe lasts one cycle and only appears with the output empty. Whether each pixel is classified correctly, whether records come out in raster order, and whether the per-frame total is right can only be shown by the bench's scenarios. These compare the output against independently computed crossing numbers for line segments, forks, solid blocks, crosses, border rings and random images, with random backpressure applied.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic {
    MT_ENDING = 1'b0,
    MT_FORK   = 1'b1
  } mtype_e;

  localparam int RING_LEN = 8;
endpackage

// File: rtl/mcd_line_buffer.sv
module mcd_line_buffer #(
  parameter int IMG_W = 256,
  localparam int XW = $clog2(IMG_W)
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic [XW-1:0] col_idx,
  input  logic          din,
  output logic          up1,
  output logic          up2
);
  // up1: pixel one row above at this column, up2: two rows above
  logic row_near [IMG_W];
  logic row_far  [IMG_W];

  assign up1 = row_near[col_idx];
  assign up2 = row_far[col_idx];

  always_ff @(posedge clk) begin
    if (shift_en) begin
      row_far[col_idx]  <= row_near[col_idx];
      row_near[col_idx] <= din;
    end
  end
endmodule

// File: rtl/mcd_window.sv
module mcd_window (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic [2:0]      col_in,   // [0] top row, [2] bottom row
  output logic [2:0][2:0] win       // [row][col], col 2 is newest
);
  logic [2:0][2:0] win_d;

  always_comb begin
    win_d = win;
    if (shift_en) begin
      for (int r = 0; r < 3; r++) begin
        win_d[r][0] = win[r][1];
        win_d[r][1] = win[r][2];
        win_d[r][2] = col_in[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_d;
  end
endmodule

// File: rtl/mcd_cn_classify.sv
module mcd_cn_classify
  import mcd_pkg::*;
(
  input  logic [2:0][2:0] win,
  output logic            is_end,
  output logic            is_fork
);
  logic [RING_LEN-1:0] ring;
  logic [RING_LEN-1:0] trans;
  logic [3:0]          tsum;
  logic [2:0]          cn;

  // clockwise from east, rows grow downward
  assign ring[0] = win[1][2]; // E
  assign ring[1] = win[2][2]; // SE
  assign ring[2] = win[2][1]; // S
  assign ring[3] = win[2][0]; // SW
  assign ring[4] = win[1][0]; // W
  assign ring[5] = win[0][0]; // NW
  assign ring[6] = win[0][1]; // N
  assign ring[7] = win[0][2]; // NE

  for (genvar k = 0; k < RING_LEN; k++) begin : g_trans
    assign trans[k] = ring[k] ^ ring[(k + 1) % RING_LEN];
  end

  always_comb begin
    tsum = '0;
    for (int k = 0; k < RING_LEN; k++) tsum = tsum + {3'b000, trans[k]};
  end

  assign cn      = tsum[3:1];
  assign is_end  = win[1][1] && (cn == 3'd1);
  assign is_fork = win[1][1] && (cn == 3'd3);
endmodule

// File: rtl/minutia_cn_detector.sv
module minutia_cn_detector
  import mcd_pkg::*;
#(
  parameter int IMG_W = 256,
  parameter int IMG_H = 300,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int CW = $clog2((IMG_W - 2) * (IMG_H - 2) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic          pix_data,
  output logic          rec_valid,
  input  logic          rec_ready,
  output logic [XW-1:0] rec_x,
  output logic [YW-1:0] rec_y,
  output logic          rec_type,
  output logic          frame_done,
  output logic [CW-1:0] frame_count
);
  localparam logic [XW-1:0] X_LAST = XW'(IMG_W - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(IMG_H - 1);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // scan position
  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic          take;
  logic          at_last;

  assign take    = pix_valid && pix_ready;
  assign at_last = (x_q == X_LAST) && (y_q == Y_LAST);

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (take) begin
      if (x_q == X_LAST) begin
        x_d = '0;
        y_d = (y_q == Y_LAST) ? '0 : y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  // neighbourhood
  logic            up1, up2;
  logic [2:0][2:0] win;
  logic            is_end, is_fork;

  mcd_line_buffer #(.IMG_W(IMG_W)) u_lines (
    .clk      (clk),
    .shift_en (take),
    .col_idx  (x_q),
    .din      (pix_data),
    .up1      (up1),
    .up2      (up2)
  );

  mcd_window u_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (take),
    .col_in   ({pix_data, up1, up2}),
    .win      (win)
  );

  mcd_cn_classify u_cls (
    .win     (win),
    .is_end  (is_end),
    .is_fork (is_fork)
  );

  // evaluation stage: one cycle after a pixel is taken, window is centred
  // one column left and one row up of that pixel
  logic          ev_v_q, ev_last_q;
  logic [XW-1:0] ev_x_q;
  logic [YW-1:0] ev_y_q;
  logic          ev_inner;
  logic          ev_hit;
  logic          ev_final;

  assign ev_inner = (ev_x_q >= XW'(2)) && (ev_y_q >= YW'(2));
  assign ev_hit   = ev_v_q && ev_inner && (is_end || is_fork);
  assign ev_final = ev_v_q && ev_last_q;

  // output record and frame bookkeeping
  logic          rv_q, rv_d;
  logic [XW-1:0] rx_q, rx_d;
  logic [YW-1:0] ry_q, ry_d;
  logic          rt_q, rt_d;
  logic [CW-1:0] tot_q, tot_d;
  logic          tail_q, tail_d;
  logic          done_w;

  assign done_w = tail_q && !rv_q;

  always_comb begin
    rv_d   = rv_q;
    rx_d   = rx_q;
    ry_d   = ry_q;
    rt_d   = rt_q;
    tot_d  = tot_q;
    tail_d = tail_q;
    if (ev_hit) begin
      rv_d  = 1'b1;
      rx_d  = ev_x_q - 1'b1;
      ry_d  = ev_y_q - 1'b1;
      rt_d  = is_fork ? MT_FORK : MT_ENDING;
      tot_d = tot_q + 1'b1;
    end else if (rec_ready) begin
      rv_d = 1'b0;
    end
    if (ev_final) tail_d = 1'b1;
    if (done_w) begin
      tail_d = 1'b0;
      tot_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      x_q       <= '0;
      y_q       <= '0;
      ev_v_q    <= 1'b0;
      ev_last_q <= 1'b0;
      ev_x_q    <= '0;
      ev_y_q    <= '0;
      rv_q      <= 1'b0;
      rx_q      <= '0;
      ry_q      <= '0;
      rt_q      <= 1'b0;
      tot_q     <= '0;
      tail_q    <= 1'b0;
    end else begin
      x_q       <= x_d;
      y_q       <= y_d;
      ev_v_q    <= take;
      ev_last_q <= take && at_last;
      if (take) begin
        ev_x_q <= x_q;
        ev_y_q <= y_q;
      end
      rv_q   <= rv_d;
      rx_q   <= rx_d;
      ry_q   <= ry_d;
      rt_q   <= rt_d;
      tot_q  <= tot_d;
      tail_q <= tail_d;
    end
  end

  assign pix_ready   = !rv_q && !ev_hit && !tail_q && !ev_final;
  assign rec_valid   = rv_q;
  assign rec_x       = rx_q;
  assign rec_y       = ry_q;
  assign rec_type    = rt_q;
  assign frame_done  = done_w;
  assign frame_count = tot_q;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker #(
  parameter int IMG_W = 256,
  parameter int IMG_H = 300,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int CW = $clog2((IMG_W - 2) * (IMG_H - 2) + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ready,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [XW-1:0] rec_x,
  input logic [YW-1:0] rec_y,
  input logic          rec_type,
  input logic          frame_done,
  input logic [CW-1:0] frame_count
);
  localparam logic [XW-1:0] X_HI = XW'(IMG_W - 2);
  localparam logic [YW-1:0] Y_HI = YW'(IMG_H - 2);

  // R7: record held while consumer stalls
  a_r7_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_x) && $stable(rec_y) && $stable(rec_type));

  // R7: input stalled while a record is pending
  a_r7_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !pix_ready);

  // R5: no border coordinates
  a_r5_no_border: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_x != '0) && (rec_x <= X_HI) && (rec_y != '0) && (rec_y <= Y_HI));

  // R8: done only with empty output
  a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !rec_valid);

  // R8: single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8: a finished frame never reports an impossible total
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_count <= CW'((IMG_W - 2) * (IMG_H - 2)));
endmodule

bind minutia_cn_detector mcd_checker #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_mcd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pix_ready   (pix_ready),
  .rec_valid   (rec_valid),
  .rec_ready   (rec_ready),
  .rec_x       (rec_x),
  .rec_y       (rec_y),
  .rec_type    (rec_type),
  .frame_done  (frame_done),
  .frame_count (frame_count)
);

// File: tb/tb_minutia_cn_detector.sv
module tb_minutia_cn_detector;
  localparam int TW = 16;
  localparam int TH = 12;
  localparam int XW = $clog2(TW);
  localparam int YW = $clog2(TH);
  localparam int CW = $clog2((TW - 2) * (TH - 2) + 1);

  logic clk, rst_n;
  logic pix_valid, pix_ready, pix_data;
  logic rec_valid, rec_ready, rec_type;
  logic [XW-1:0] rec_x;
  logic [YW-1:0] rec_y;
  logic frame_done;
  logic [CW-1:0] frame_count;

  minutia_cn_detector #(.IMG_W(TW), .IMG_H(TH)) dut (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_x(rec_x), .rec_y(rec_y), .rec_type(rec_type),
    .frame_done(frame_done), .frame_count(frame_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct { int x; int y; int t; } exp_t;
  exp_t  expq[$];
  int    n_tests = 0, n_fail = 0;
  bit    img [TH][TW];
  string cur_tag = "";
  bit    bp_on = 0;
  bit    mon_on = 0;
  bit    done_seen = 0;
  int    done_val = 0;
  bit    prev_stall = 0;
  int    px, py, pt;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_cn(input int x, input int y);
    int dx[8] = '{1, 1, 0, -1, -1, -1, 0, 1};
    int dy[8] = '{0, 1, 1, 1, 0, -1, -1, -1};
    int s = 0;
    for (int k = 0; k < 8; k++) begin
      int a = img[y + dy[k]][x + dx[k]];
      int b = img[y + dy[(k + 1) % 8]][x + dx[(k + 1) % 8]];
      s += (a > b) ? a - b : b - a;
    end
    return s / 2;
  endfunction

  function automatic int build_expect();
    int n = 0;
    expq.delete();
    for (int y = 1; y < TH - 1; y++)
      for (int x = 1; x < TW - 1; x++)
        if (img[y][x]) begin
          int c = ref_cn(x, y);
          if (c == 1 || c == 3) begin
            exp_t e;
            e.x = x; e.y = y; e.t = (c == 3) ? 1 : 0;
            expq.push_back(e);
            n++;
          end
        end
    return n;
  endfunction

  task automatic clear_img();
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++) img[y][x] = 1'b0;
  endtask

  task automatic run_frame(input string tag, input bit bp);
    int nexp;
    int t;
    nexp = build_expect();
    cur_tag = tag;
    bp_on = bp;
    done_seen = 0;
    @(negedge clk);
    for (int y = 0; y < TH; y++)
      for (int x = 0; x < TW; x++) begin
        pix_valid = 1'b1;
        pix_data  = img[y][x];
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
      end
    pix_valid = 1'b0;
    t = 0;
    while (!done_seen && t < 3000) begin @(negedge clk); t++; end
    chk(done_seen, "R8", done_seen, 1, {tag, " frame_done seen"});
    chk(done_val == nexp, "R8", done_val, nexp, {tag, " frame_count"});
    chk(expq.size() == 0, "R6", expq.size(), 0, {tag, " records left unseen"});
  endtask

  // monitor / scoreboard and consumer
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall) begin
        chk(rec_valid == 1'b1 && rec_x == px && rec_y == py && rec_type == pt,
            "R7", {rec_x, rec_y}, (px << YW) | py, "record held during stall");
        chk(pix_ready == 1'b0, "R7", pix_ready, 0, "input stalled while record pending");
      end
      rec_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      if (rec_valid && rec_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3/R4", rec_x * 100 + rec_y, -1, {cur_tag, " unexpected record"});
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(rec_x == e.x && rec_y == e.y, "R6", rec_x * 100 + rec_y, e.x * 100 + e.y,
              {cur_tag, " coordinates"});
          chk(rec_type == e.t, (e.t == 1) ? "R2" : "R1", rec_type, e.t, {cur_tag, " type"});
        end
      end
      prev_stall = rec_valid && !rec_ready;
      px = rec_x; py = rec_y; pt = rec_type;
      if (frame_done) begin
        done_seen = 1;
        done_val  = frame_count;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    pix_valid = 1'b0;
    pix_data  = 1'b0;
    rec_ready = 1'b1;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rec_valid == 1'b0, "R7", rec_valid, 0, "reset rec_valid");
    chk(frame_done == 1'b0, "R8", frame_done, 0, "reset frame_done");
    chk(pix_ready == 1'b1, "R7", pix_ready, 1, "reset pix_ready");
    mon_on = 1;

    // R1/R3/R4: straight segment, two endings, middle continuing, background quiet
    clear_img();
    for (int x = 3; x <= 9; x++) img[4][x] = 1'b1;
    run_frame("R1/R3/R4 segment", 1'b1);

    // R2: fork
    clear_img();
    img[9][8] = 1; img[8][8] = 1; img[7][8] = 1; img[6][8] = 1;
    img[5][7] = 1; img[4][6] = 1; img[5][9] = 1; img[4][10] = 1;
    run_frame("R2 fork", 1'b0);

    // R9: 2x2 block, three set neighbours each, all endings
    clear_img();
    img[5][5] = 1; img[5][6] = 1; img[6][5] = 1; img[6][6] = 1;
    run_frame("R9 block", 1'b0);

    // R5: ridge border plus interior pixel touching it at column 1
    clear_img();
    for (int x = 0; x < TW; x++) begin img[0][x] = 1; img[TH-1][x] = 1; end
    for (int y = 0; y < TH; y++) begin img[y][0] = 1; img[y][TW-1] = 1; end
    img[5][1] = 1;
    run_frame("R5 border", 1'b1);

    // R3: cross centre (crossing number 4) and isolated pixel (0)
    clear_img();
    img[6][8] = 1; img[5][8] = 1; img[7][8] = 1; img[6][7] = 1; img[6][9] = 1;
    img[3][3] = 1;
    run_frame("R3 cross", 1'b0);

    // R6/R8: random images with backpressure, count restarts each frame
    for (int f = 0; f < 4; f++) begin
      for (int y = 0; y < TH; y++)
        for (int x = 0; x < TW; x++) img[y][x] = (($urandom % 100) < 35);
      run_frame("R6 random", 1'b1);
    end

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule